// File: doc/BRIEF.md
# Polarity-Adaptive Current Trip Logic

This block is the digital protection stage of a single-phase bridgeless power-factor-correction converter. Each signed inductor-current sample goes through two comparison paths. One path looks for overcurrent and the other looks for reverse current. Each path keeps one threshold for the positive line half-cycle and another for the negative half-cycle. When the line is negative, the raw comparison of each path is inverted. This keeps both trip outputs active-high whatever the line polarity.

The active polarity and the active thresholds never change while the power switches may be conducting. A polarity change on the line input waits, as do threshold writes. Both are applied together on the next rising edge of the dead-window input, which marks the interval around zero crossing when every PWM output is off. A programmable blanking interval follows each such update and stops the trip flags from setting while the new references settle. The default blanking interval is 250 cycles, which is 1 µs at 250 MHz.

The trip flags latch once set and clear only on an explicit clear input. A shutdown request is raised while either flag is set. Samples arrive on a valid/ready stream. The block accepts a sample on every cycle and never applies back-pressure, so `smp_ready` is permanently high. A sample counts only in a cycle where `smp_valid` is high.

Top module: `ctg_trip_guard`

## Requirements
- R1: `smp_ready` is high in every cycle after reset. A sample presented while `smp_valid` is low never sets a flag.
- R2: With positive polarity active, the overcurrent flag sets after the clock edge that accepts a sample strictly greater than the positive overcurrent threshold. A sample equal to that threshold does not set it.
- R3: With negative polarity active, the overcurrent path result is inverted. The flag sets for a sample less than or equal to the negative overcurrent threshold.
- R4: With positive polarity active, the reverse flag sets for a sample strictly less than the positive reverse threshold. A sample equal to that threshold does not set it.
- R5: With negative polarity active, the reverse path result is inverted. The flag sets for a sample greater than or equal to the negative reverse threshold.
- R6: A change of `line_neg` (1 = negative half-cycle) takes effect only at a rising edge of `dead_win`. Until that edge the previous polarity stays in use.
- R7: A write places `cfg_data` in a staging register chosen by `cfg_sel`: 0 = positive overcurrent, 1 = negative overcurrent, 2 = positive reverse, 3 = negative reverse. The comparators keep using the old value until the next rising edge of `dead_win`.
- R8: An update happens only at a `dead_win` rising edge where a polarity change or a write is pending. A rising edge with nothing pending changes nothing and starts no blanking.
- R9: Samples accepted at the update edge do not set either flag. The same holds for samples accepted at the following BLANK_CYCLES edges.
- R10: A set flag stays set until a cycle with `trip_clr` high. If a trip and a clear fall in the same cycle, the flag ends up set.
- R11: `shutdown_req` is high exactly when at least one flag is set.
- R12: After reset both flags are low, positive polarity is active and no blanking runs. The thresholds come out of reset at their safe extremes: overcurrent positive at the maximum, overcurrent negative at the minimum, reverse positive at the minimum and reverse negative at the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Current sample valid |
| smp_ready | output | 1 | Sample accepted (always high) |
| smp_data | input | SMP_W | Signed two's-complement inductor current |
| line_neg | input | 1 | Requested line polarity, 1 = negative half-cycle |
| dead_win | input | 1 | All-switches-off window around zero crossing |
| cfg_we | input | 1 | Threshold staging write strobe |
| cfg_sel | input | 2 | Threshold select (see R7) |
| cfg_data | input | SMP_W | Threshold value, signed |
| trip_clr | input | 1 | Clears both trip flags |
| trip_oc | output | 1 | Latched overcurrent flag |
| trip_rc | output | 1 | Latched reverse-current flag |
| shutdown_req | output | 1 | Request to shut down the converter |

## Verification
Directed samples placed on and next to each threshold in both polarities check the inclusive and exclusive edges of each compare. They also check which polarity inverts which path. Polarity changes and threshold writes sent outside the dead window, followed later by a dead-window pulse, show the difference between a held update and an applied one. A pulse with nothing pending shows that no blanking starts. Long random runs of samples mix valid gaps, clears, polarity toggles, writes and dead-window pulses, and compare every cycle with a reference model. These runs expose errors in latching, set-over-clear priority and the length of the blanking window.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
  typedef enum logic [1:0] {
    THR_OC_POS = 2'd0,
    THR_OC_NEG = 2'd1,
    THR_RC_POS = 2'd2,
    THR_RC_NEG = 2'd3
  } thr_sel_e;

  typedef enum logic {
    PATH_OVER = 1'b0,
    PATH_REV  = 1'b1
  } path_kind_e;

  localparam int unsigned NUM_THR = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_THR);
endpackage

// File: rtl/ctg_update_ctrl.sv
module ctg_update_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic line_neg,
  input  logic dead_win,
  input  logic thr_dirty,
  output logic upd,
  output logic act_neg
);
  logic dead_q;
  logic pol_pend;

  assign pol_pend = line_neg ^ act_neg;
  assign upd      = dead_win & ~dead_q & (pol_pend | thr_dirty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dead_q  <= 1'b0;
      act_neg <= 1'b0;
    end else begin
      dead_q <= dead_win;
      if (upd) act_neg <= line_neg;
    end
  end

  // R6: active polarity moves only inside the dead window
  assert_pol_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dead_win |=> $stable(act_neg));
endmodule

// File: rtl/ctg_thr_bank.sv
module ctg_thr_bank #(
  parameter int unsigned W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [ctg_pkg::SEL_W-1:0]     cfg_sel,
  input  logic signed [W-1:0]           cfg_data,
  input  logic                          upd,
  output logic                          thr_dirty,
  output logic signed [W-1:0]           act_thr [ctg_pkg::NUM_THR]
);
  import ctg_pkg::*;

  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] stg [NUM_THR];

  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    localparam logic signed [W-1:0] RSTV =
      ((i == int'(THR_OC_POS)) || (i == int'(THR_RC_NEG))) ? MAXV : MINV;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[i]     <= RSTV;
        act_thr[i] <= RSTV;
      end else begin
        if (upd) act_thr[i] <= stg[i];
        if (cfg_we && (cfg_sel == SEL_W'(i))) stg[i] <= cfg_data;
      end
    end

    // R7: active thresholds move only on an update
    assert_thr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(act_thr[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_dirty <= 1'b0;
    else if (cfg_we) thr_dirty <= 1'b1;
    else if (upd)    thr_dirty <= 1'b0;
  end
endmodule

// File: rtl/ctg_blank_timer.sv
module ctg_blank_timer #(
  parameter int unsigned BLANK_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  output logic blank
);
  localparam int unsigned CW = $clog2(BLANK_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign blank = upd | (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (upd)        cnt <= CW'(BLANK_CYCLES);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  // R9: an update is always followed by a blanked cycle
  assert_blank_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> blank);
endmodule

// File: rtl/ctg_trip_path.sv
module ctg_trip_path #(
  parameter int unsigned         W    = 16,
  parameter ctg_pkg::path_kind_e KIND = ctg_pkg::PATH_OVER
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [W-1:0]  thr_pos,
  input  logic signed [W-1:0]  thr_neg,
  input  logic                 act_neg,
  input  logic                 fire,
  input  logic signed [W-1:0]  smp,
  input  logic                 blank,
  input  logic                 clr,
  output logic                 flag
);
  logic signed [W-1:0] thr;
  logic raw;
  logic hit;

  assign thr = act_neg ? thr_neg : thr_pos;

  if (KIND == ctg_pkg::PATH_OVER) begin : g_over
    assign raw = smp > thr;
  end else begin : g_rev
    assign raw = smp < thr;
  end

  assign hit = raw ^ act_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~clr) | (fire & ~blank & hit);
  end

  // R10: a set flag survives any cycle without a clear
  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
  // R9: a clear flag cannot set while blanking is active
  assert_blank_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && blank |=> !flag);
  // R1: without a valid sample a clear flag stays clear
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && !fire |=> !flag);
endmodule

// File: rtl/ctg_trip_guard.sv
module ctg_trip_guard #(
  parameter int unsigned SMP_W        = 16,
  parameter int unsigned BLANK_CYCLES = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             line_neg,
  input  logic             dead_win,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [SMP_W-1:0] cfg_data,
  input  logic             trip_clr,
  output logic             trip_oc,
  output logic             trip_rc,
  output logic             shutdown_req
);
  import ctg_pkg::*;

  logic                    upd;
  logic                    act_neg;
  logic                    thr_dirty;
  logic                    blank;
  logic                    fire;
  logic signed [SMP_W-1:0] smp_s;
  logic signed [SMP_W-1:0] act_thr [NUM_THR];

  assign smp_ready = 1'b1;
  assign fire      = smp_valid & smp_ready;
  assign smp_s     = $signed(smp_data);

  ctg_update_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_neg  (line_neg),
    .dead_win  (dead_win),
    .thr_dirty (thr_dirty),
    .upd       (upd),
    .act_neg   (act_neg)
  );

  ctg_thr_bank #(.W(SMP_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_data  ($signed(cfg_data)),
    .upd       (upd),
    .thr_dirty (thr_dirty),
    .act_thr   (act_thr)
  );

  ctg_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd),
    .blank (blank)
  );

  ctg_trip_path #(.W(SMP_W), .KIND(PATH_OVER)) u_oc (
    .clk     (clk),
    .rst_n   (rst_n),
    .thr_pos (act_thr[THR_OC_POS]),
    .thr_neg (act_thr[THR_OC_NEG]),
    .act_neg (act_neg),
    .fire    (fire),
    .smp     (smp_s),
    .blank   (blank),
    .clr     (trip_clr),
    .flag    (trip_oc)
  );

  ctg_trip_path #(.W(SMP_W), .KIND(PATH_REV)) u_rc (
    .clk     (clk),
    .rst_n   (rst_n),
    .thr_pos (act_thr[THR_RC_POS]),
    .thr_neg (act_thr[THR_RC_NEG]),
    .act_neg (act_neg),
    .fire    (fire),
    .smp     (smp_s),
    .blank   (blank),
    .clr     (trip_clr),
    .flag    (trip_rc)
  );

  assign shutdown_req = trip_oc | trip_rc;
endmodule

// File: tb/test_ctg_trip_guard.sv
module test_ctg_trip_guard;
  localparam int BLANK = 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [15:0] smp_data = '0;
  logic line_neg = 1'b0;
  logic dead_win = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic trip_clr = 1'b0;
  logic trip_oc, trip_rc, shutdown_req;

  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  bit m_neg = 0;
  int m_act [4] = '{32767, -32768, -32768, 32767};
  int m_stg [4] = '{32767, -32768, -32768, 32767};
  bit m_dirty = 0;
  int m_bcnt = 0;
  bit m_dq = 0;
  bit m_oc = 0;
  bit m_rc = 0;

  always #2 clk = ~clk;

  ctg_trip_guard i_ctg_trip_guard (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .line_neg(line_neg), .dead_win(dead_win),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .trip_clr(trip_clr), .trip_oc(trip_oc), .trip_rc(trip_rc),
    .shutdown_req(shutdown_req)
  );

  function automatic bit oc_hit(bit neg, int s, int tp, int tn);
    return neg ? (s <= tn) : (s > tp);
  endfunction

  function automatic bit rc_hit(bit neg, int s, int tp, int tn);
    return neg ? (s >= tn) : (s < tp);
  endfunction

  task automatic model_step();
    bit rise, upd, blank, fire;
    int s;
    s     = int'($signed(smp_data));
    fire  = smp_valid;
    rise  = dead_win && !m_dq;
    upd   = rise && ((line_neg != m_neg) || m_dirty);
    blank = upd || (m_bcnt != 0);
    m_oc  = (m_oc && !trip_clr) || (fire && !blank && oc_hit(m_neg, s, m_act[0], m_act[1]));
    m_rc  = (m_rc && !trip_clr) || (fire && !blank && rc_hit(m_neg, s, m_act[2], m_act[3]));
    if (upd) begin
      m_neg = line_neg;
      for (int i = 0; i < 4; i++) m_act[i] = m_stg[i];
      m_bcnt = BLANK;
    end else if (m_bcnt != 0) begin
      m_bcnt = m_bcnt - 1;
    end
    if (cfg_we) begin
      m_stg[cfg_sel] = int'($signed(cfg_data));
      m_dirty = 1;
    end else if (upd) begin
      m_dirty = 0;
    end
    m_dq = dead_win;
  endtask

  task automatic cmp(string tag);
    n_vec++;
    if (trip_oc !== m_oc || trip_rc !== m_rc || shutdown_req !== (m_oc | m_rc) || smp_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: oc/rc/sd/rdy = %b%b%b%b expected %b%b%b1", tag,
               trip_oc, trip_rc, shutdown_req, smp_ready, m_oc, m_rc, m_oc | m_rc);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic expect_flags(string tag, bit eoc, bit erc);
    n_vec++;
    if (trip_oc !== eoc || trip_rc !== erc || shutdown_req !== (eoc | erc)) begin
      n_bad++;
      $display("FAIL %s: oc/rc/sd = %b%b%b expected %b%b%b", tag,
               trip_oc, trip_rc, shutdown_req, eoc, erc, eoc | erc);
    end
  endtask

  task automatic smp(int v, bit vld, bit clr, string tag);
    smp_data = 16'(v); smp_valid = vld; trip_clr = clr;
    tick(tag);
    smp_valid = 0; trip_clr = 0;
  endtask

  task automatic wr(int sel, int v);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_data = 16'(v);
    tick("R7");
    cfg_we = 0;
  endtask

  task automatic dead_pulse();
    dead_win = 1; tick("R8");
    dead_win = 0; tick("R8");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick("R9");
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run incomplete, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp("R12");
    expect_flags("R12", 0, 0);

    // program thresholds, apply through a dead window
    wr(0, 1000); wr(1, -1000); wr(2, -200); wr(3, 200);
    smp(5000, 1, 0, "R7");
    expect_flags("R7", 0, 0);
    dead_win = 1; smp(5000, 1, 0, "R9");   // update edge, blanked
    dead_win = 0;
    for (int i = 0; i < BLANK; i++) smp(5000, 1, 0, "R9");
    expect_flags("R9", 0, 0);
    smp(5000, 1, 0, "R9");
    expect_flags("R9", 1, 0);
    smp(0, 0, 1, "R10");
    expect_flags("R10", 0, 0);

    // positive-polarity boundaries
    smp(1000, 1, 0, "R2"); expect_flags("R2", 0, 0);
    smp(1001, 1, 0, "R2"); expect_flags("R2", 1, 0);
    smp(0, 0, 0, "R10");   expect_flags("R10", 1, 0);
    smp(0, 0, 1, "R10");
    smp(30000, 0, 0, "R1"); expect_flags("R1", 0, 0);
    smp(1001, 1, 1, "R10"); expect_flags("R10", 1, 0);
    smp(0, 0, 1, "R10");
    smp(-200, 1, 0, "R4"); expect_flags("R4", 0, 0);
    smp(-201, 1, 0, "R4"); expect_flags("R11", 0, 1);
    smp(0, 0, 1, "R10");

    // polarity request held outside the dead window
    line_neg = 1;
    smp(-1500, 1, 0, "R6"); expect_flags("R6", 0, 1);
    smp(0, 0, 1, "R6");
    dead_pulse();
    idle(BLANK);
    smp(-1000, 1, 0, "R3"); expect_flags("R3", 1, 0);
    smp(0, 0, 1, "R3");
    smp(-999, 1, 0, "R3");  expect_flags("R3", 0, 0);
    smp(200, 1, 0, "R5");   expect_flags("R5", 0, 1);
    smp(0, 0, 1, "R5");
    smp(199, 1, 0, "R5");   expect_flags("R5", 0, 0);

    // staged write, not applied until dead window
    wr(1, -500);
    smp(-700, 1, 0, "R7"); expect_flags("R7", 0, 0);
    dead_pulse();
    idle(BLANK);
    smp(-700, 1, 0, "R7"); expect_flags("R7", 1, 0);
    smp(0, 0, 1, "R7");

    // dead window with nothing pending: no blanking
    dead_win = 1; smp(-700, 1, 0, "R8");
    dead_win = 0; expect_flags("R8", 1, 0);
    smp(0, 0, 1, "R8");

    // random phase checked against the model
    begin
      int dw_left = 0;
      for (int c = 0; c < 6000; c++) begin
        int v;
        v = int'($urandom % 3001) - 1500;
        smp_data  = 16'(v);
        smp_valid = ($urandom % 4) != 0;
        trip_clr  = ($urandom % 16) == 0;
        if (($urandom % 200) == 0) line_neg = ~line_neg;
        if (dw_left > 0) dw_left--;
        else if (($urandom % 150) == 0) dw_left = 6;
        dead_win = dw_left > 0;
        cfg_we   = ($urandom % 100) == 0;
        cfg_sel  = 2'($urandom % 4);
        cfg_data = 16'(int'($urandom % 3001) - 1500);
        tick("R2/R3/R4/R5/R6/R7/R8/R9/R10/R11");
      end
      smp_valid = 0; trip_clr = 0; cfg_we = 0; dead_win = 0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule